// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix-Vector Array

This block is an N×N grid of multiply-accumulate cells that evaluates y = W·x for a stream of input vectors. Every cell keeps one signed 4-bit weight in a local register and reuses it for every vector that passes, so no operand is ever selected from a shared register file. Cells talk only to their neighbours: activations move one column to the right per cycle, partial sums move one row down per cycle, and each column's finished 16-bit sum leaves at the bottom edge.

Weights enter through a boundary port one row wide (N lanes). Each load strobe pushes every stored row down by one, so a full weight set takes N strobes. That is slower than a port per cell, but the edge wiring grows with N instead of N². Once a set is in place, the array takes one new input vector per clock with no gaps. Input element i is delayed by i cycles inside the block, so each partial sum meets the matching activation in every cell. Result element j comes out j cycles after element 0 and carries its own valid bit.

Top module: `wsmv_array`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `load_done` is 0, every `y_valid` bit is 0 and `y_out` is all zeros.
- R2: Each `w_load` strobe moves every stored weight row one row down and places `w_row` in row 0. Lane j of `w_row` (bits `[4j+3:4j]`) goes to column j. After N strobes, the word of the last strobe sits in row 0 and the word of the first strobe sits in row N-1. Row i multiplies input element i.
- R3: `load_done` rises in the cycle after the N-th strobe counted from reset or from the last completed load. It stays high until the next strobe, and that strobe clears it and starts a new count. It never rises except after a strobe.
- R4: A vector is accepted only in a cycle with `x_valid`=1, `load_done`=1 and `w_load`=0. A vector presented in any other cycle produces no `y_valid` pulse.
- R5: For an accepted vector, result lane j (bits `[16j+15:16j]` of `y_out`) equals the sum over i of w[i][j]·x[i]. Weights and inputs are 4-bit two's complement, input element i is in bits `[4i+3:4i]` of `x_in`, and the sum is a 16-bit two's complement value.
- R6: Lane j of a vector accepted at a rising edge is valid for exactly one cycle, after the (N+j)-th rising edge, counting the accepting edge as the first. `y_valid[j+1]` is high only in the cycle after a cycle in which `y_valid[j]` was high.
- R7: A vector may be accepted in every cycle without gaps. Each accepted vector yields exactly one valid result on every lane, and results stay in acceptance order with the stored weights reused unchanged.
- R8: A result lane whose `y_valid` bit is 0 reads as zero.
- R9: Full-scale operands do not wrap. With every weight and every input element at -8, each lane returns +64·N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| w_load | input | 1 | Weight row strobe; shifts stored rows down by one |
| w_row | input | N*4 | One row of weights, lane j for column j |
| load_done | output | 1 | A complete weight set is stored |
| x_valid | input | 1 | Input vector present this cycle |
| x_in | input | N*4 | Input vector, element i in lane i |
| y_valid | output | N | Per-lane result valid |
| y_out | output | N*16 | Result vector, lane j is output element j |

## Verification
The assertions assume N is at least 2 and that weights are not reloaded while earlier vectors are still moving through the grid. A reload in flight would mix two weight sets into one result without breaking any protocol rule. The stimulus waits at least 3N idle cycles after the last accepted vector before it strobes a new row, and it holds `x_valid` high during loads and before the first load only to show that those vectors are dropped. The sweeps use an N=4 array: one weight set against all 65,536 input vectors, and a full-scale negative weight set against a further sweep that includes the all -8 vector.

// File: rtl/wsmv_pkg.sv
`timescale 1ns/1ps
package wsmv_pkg;

    localparam int WW = 4;   // weight width
    localparam int XW = 4;   // activation width
    localparam int AW = 16;  // accumulator width

    typedef logic signed [WW-1:0] wgt_t;
    typedef logic signed [XW-1:0] act_t;
    typedef logic signed [AW-1:0] acc_t;

    // State a cell passes on to its right and lower neighbours
    typedef struct packed {
        act_t x;
        acc_t psum;
    } flow_t;

    // Narrow product, widened before it joins the running sum
    function automatic acc_t mac(input acc_t acc, input wgt_t w, input act_t x);
        logic signed [WW+XW-1:0] prod;
        prod = w * x;
        return acc + AW'(prod);
    endfunction

endpackage

// File: rtl/wsmv_cell.sv
`timescale 1ns/1ps
module wsmv_cell
    import wsmv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic w_shift,
    input  wgt_t w_in,
    output wgt_t w_q,
    input  act_t x_in,
    input  acc_t psum_in,
    output act_t x_q,
    output acc_t psum_q
);

    flow_t flow_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q    <= '0;
            flow_r <= '0;
        end else begin
            if (w_shift) begin
                w_q <= w_in;
            end
            flow_r.x    <= x_in;
            flow_r.psum <= mac(psum_in, w_q, x_in);
        end
    end

    assign x_q    = flow_r.x;
    assign psum_q = flow_r.psum;

endmodule

// File: rtl/wsmv_skew.sv
`timescale 1ns/1ps
module wsmv_skew
    import wsmv_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [N*XW-1:0] x_bus,
    output act_t          x_row [N]
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        act_t x_gated;
        assign x_gated = take ? act_t'(x_bus[i*XW +: XW]) : act_t'(0);

        if (i == 0) begin : g_direct
            assign x_row[i] = x_gated;
        end else begin : g_delay
            act_t stage [i];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < i; k++) stage[k] <= '0;
                end else begin
                    stage[0] <= x_gated;
                    for (int k = 1; k < i; k++) stage[k] <= stage[k-1];
                end
            end
            assign x_row[i] = stage[i-1];
        end
    end

endmodule

// File: rtl/wsmv_loadctl.sv
`timescale 1ns/1ps
module wsmv_loadctl #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic w_load,
    output logic load_done
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] rows_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_in <= '0;
        end else if (w_load) begin
            rows_in <= (rows_in == CW'(N)) ? CW'(1) : rows_in + CW'(1);
        end
    end

    assign load_done = (rows_in == CW'(N));

endmodule

// File: rtl/wsmv_vpipe.sv
`timescale 1ns/1ps
module wsmv_vpipe #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    output logic [N-1:0] y_valid
);

    localparam int DEPTH = 2 * N - 1;

    logic [DEPTH-1:0] tag_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_sr <= '0;
        end else begin
            tag_sr <= {tag_sr[DEPTH-2:0], take};
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_tap
        assign y_valid[j] = tag_sr[N-1+j];
    end

endmodule

// File: rtl/wsmv_array.sv
`timescale 1ns/1ps
module wsmv_array
    import wsmv_pkg::*;
#(
    parameter int N = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            w_load,
    input  logic [N*WW-1:0] w_row,
    output logic            load_done,
    input  logic            x_valid,
    input  logic [N*XW-1:0] x_in,
    output logic [N-1:0]    y_valid,
    output logic [N*AW-1:0] y_out
);

    logic take;
    act_t x_row [N];

    wgt_t w_v [N+1][N];   // weight rows moving down
    act_t x_h [N][N+1];   // activations moving right
    acc_t p_v [N+1][N];   // partial sums moving down

    assign take = x_valid & load_done & ~w_load;

    wsmv_loadctl #(.N(N)) u_loadctl (
        .clk      (clk),
        .rst      (rst),
        .w_load   (w_load),
        .load_done(load_done)
    );

    wsmv_skew #(.N(N)) u_skew (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .x_bus(x_in),
        .x_row(x_row)
    );

    wsmv_vpipe #(.N(N)) u_vpipe (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .y_valid(y_valid)
    );

    for (genvar j = 0; j < N; j++) begin : g_edge_col
        assign w_v[0][j] = wgt_t'(w_row[j*WW +: WW]);
        assign p_v[0][j] = '0;
        assign y_out[j*AW +: AW] = p_v[N][j];
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        assign x_h[i][0] = x_row[i];
        for (genvar j = 0; j < N; j++) begin : g_col
            wsmv_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .w_shift(w_load),
                .w_in   (w_v[i][j]),
                .w_q    (w_v[i+1][j]),
                .x_in   (x_h[i][j]),
                .psum_in(p_v[i][j]),
                .x_q    (x_h[i][j+1]),
                .psum_q (p_v[i+1][j])
            );
        end
    end

endmodule

// File: rtl/wsmv_array_chk.sv
`timescale 1ns/1ps
module wsmv_array_chk
    import wsmv_pkg::*;
#(
    parameter int N = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            w_load,
    input logic            load_done,
    input logic [N-1:0]    y_valid,
    input logic [N*AW-1:0] y_out
);

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (w_load && load_done) |=> !load_done); // R3

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!w_load && load_done) |=> load_done); // R3

    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> $past(w_load)); // R3

    for (genvar j = 0; j < N; j++) begin : g_lane_chk
        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !y_valid[j] |-> (y_out[j*AW +: AW] == '0)); // R8
    end

    for (genvar j = 1; j < N; j++) begin : g_chain_chk
        AST_VALID_CHAIN: assert property (@(posedge clk) disable iff (rst)
            y_valid[j] |-> $past(y_valid[j-1])); // R6
    end

endmodule

bind wsmv_array wsmv_array_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .w_load   (w_load),
    .load_done(load_done),
    .y_valid  (y_valid),
    .y_out    (y_out)
);

// File: tb/wsmv_array_tb_top.sv
`timescale 1ns/1ps
module wsmv_array_tb_top;
    import wsmv_pkg::*;

    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            w_load = 1'b0;
    logic [N*WW-1:0] w_row = '0;
    logic            load_done;
    logic            x_valid = 1'b0;
    logic [N*XW-1:0] x_in = '0;
    logic [N-1:0]    y_valid;
    logic [N*AW-1:0] y_out;

    int n_run = 0;
    int n_fail = 0;
    int wt [N][N];
    int mon_set = 0;
    bit mon_on = 1'b0;
    int lane_cnt [N];
    int any_valid = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    wsmv_array #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .w_load(w_load), .w_row(w_row),
        .load_done(load_done), .x_valid(x_valid), .x_in(x_in),
        .y_valid(y_valid), .y_out(y_out)
    );

    function automatic int xval(int set, int v, int i);
        if (set == 0) return ((v >> (4 * i)) & 15) - 8;
        return ((v * 37 + i * 11 + 5) % 16) - 8;
    endfunction

    function automatic int expect_y(int set, int v, int j);
        int s = 0;
        for (int i = 0; i < N; i++) s += wt[i][j] * xval(set, v, i);
        return s;
    endfunction

    function automatic logic [N*XW-1:0] pack_x(int set, int v);
        logic [N*XW-1:0] r;
        for (int i = 0; i < N; i++) r[i*XW +: XW] = XW'(xval(set, v, i));
        return r;
    endfunction

    function automatic logic [N*WW-1:0] pack_w(int row);
        logic [N*WW-1:0] r;
        for (int j = 0; j < N; j++) r[j*WW +: WW] = WW'(wt[row][j]);
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Result monitor: values of valid lanes, zeros on idle lanes
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int j = 0; j < N; j++) begin
                int got;
                got = int'($signed(y_out[j*AW +: AW]));
                if (y_valid[j]) begin
                    any_valid++;
                    if (mon_on) begin
                        chk(got == expect_y(mon_set, lane_cnt[j], j), "R2/R5/R9 lane value",
                            got, expect_y(mon_set, lane_cnt[j], j));
                        lane_cnt[j]++;
                    end
                end else begin
                    chk(got == 0, "R8 idle lane zero", got, 0);
                end
            end
        end
    end

    // Rows go in bottom-first: the last strobe lands in row 0 (R2)
    task automatic load_weights(bit hold_x);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            if (k > 0) chk(load_done == 1'b0, "R3 done low mid-load", int'(load_done), 0);
            w_load  = 1'b1;
            w_row   = pack_w(N - 1 - k);
            x_valid = hold_x;
            x_in    = {N{4'h5}};
        end
        @(negedge clk);
        chk(load_done == 1'b1, "R3 done after N strobes", int'(load_done), 1);
        w_load  = 1'b0;
        x_valid = 1'b0;
    endtask

    task automatic run_stream(int set, int nvec);
        mon_set = set;
        for (int j = 0; j < N; j++) lane_cnt[j] = 0;
        mon_on = 1'b1;
        for (int v = 0; v < nvec; v++) begin
            @(negedge clk);
            x_valid = 1'b1;
            x_in    = pack_x(set, v);
        end
        @(negedge clk);
        x_valid = 1'b0;
        repeat (3 * N) @(negedge clk);
        for (int j = 0; j < N; j++)
            chk(lane_cnt[j] == nvec, "R7 one result per vector", lane_cnt[j], nvec);
        mon_on = 1'b0;
    endtask

    task automatic latency_test();
        int first [N];
        int seen [N];
        for (int j = 0; j < N; j++) begin first[j] = -1; seen[j] = 0; end
        mon_set = 1;
        for (int j = 0; j < N; j++) lane_cnt[j] = 0;
        mon_on = 1'b1;
        @(negedge clk);
        x_valid = 1'b1;
        x_in    = pack_x(1, 0);
        @(negedge clk);
        x_valid = 1'b0;
        for (int e = 1; e <= 3 * N; e++) begin
            for (int j = 0; j < N; j++) begin
                if (y_valid[j]) begin
                    seen[j]++;
                    if (first[j] < 0) first[j] = e;
                end
            end
            @(negedge clk);
        end
        for (int j = 0; j < N; j++) begin
            chk(first[j] == N + j, "R6 lane latency", first[j], N + j);
            chk(seen[j] == 1, "R6 single-cycle valid", seen[j], 1);
        end
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(load_done == 1'b0, "R1 done in reset", int'(load_done), 0);
        chk(y_valid == '0, "R1 valid in reset", int'(y_valid), 0);
        chk(y_out == '0, "R1 out in reset", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(load_done == 1'b0 && y_valid == '0, "R1 after release", int'(load_done), 0);

        // R4: vectors before any load are dropped
        any_valid = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            x_valid = 1'b1;
            x_in    = pack_x(1, k);
        end
        @(negedge clk);
        x_valid = 1'b0;
        repeat (3 * N) @(negedge clk);
        chk(any_valid == 0, "R4 dropped before load", any_valid, 0);

        // Weight set A, with x_valid held during the load (R4)
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wt[i][j] = ((i * 5 + j * 3 + 1) % 16) - 8;
        load_weights(1'b1);
        repeat (3 * N) @(negedge clk);
        chk(any_valid == 0, "R4 dropped during load", any_valid, 0);

        latency_test();
        run_stream(0, 65536);

        // Weight set B: full-scale negative; first strobe clears done (R3)
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wt[i][j] = -8;
        load_weights(1'b0);
        run_stream(0, 256);
        chk(expect_y(0, 0, 0) == 64 * N, "R9 full-scale reference", expect_y(0, 0, 0), 64 * N);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule